// File: doc/BRIEF.md
# Microcoded Instruction Sequencer for a Shared-Bus 8-bit Machine

This block is the control unit of a small 8-bit machine whose registers, memory, adder and program counter all share one data bus. Each clock cycle it asserts a set of control strobes. A strobe either puts one unit's value onto the bus or has one unit capture the bus. The datapath obeys the strobes at the next rising edge. Every instruction begins with the same two fetch steps. After those steps the instruction register holds the new instruction word, and the sequencer decodes its upper four bits (the opcode). The lower four bits are the operand, and the datapath places them on the bus when the operand-out strobe is asserted. The sequencer then plays one or two execute steps and returns to fetch. A halt opcode stops it until reset.

The design has five named states. FETCH_ADDR (step 0) drives the program counter onto the bus and loads the memory address register. FETCH_WORD (step 1) drives the memory word into the instruction register and increments the program counter. EXEC_A (step 2) plays the first micro-step of the opcode. EXEC_B (step 3) plays the second micro-step of a two-step opcode. STOPPED is the halt state.

The transitions are as follows. Reset enters FETCH_ADDR. FETCH_ADDR always goes to FETCH_WORD, and FETCH_WORD always goes to EXEC_A. EXEC_A goes to STOPPED on the halt opcode, to FETCH_ADDR on an opcode that has a single execute step (or none), and to EXEC_B otherwise. EXEC_B always returns to FETCH_ADDR. STOPPED stays in STOPPED until reset.

Top module: `ucode_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, step_idx is 0, halted is 0 and ctl equals the FETCH_ADDR pattern, which is bits 1 and 3 set.
- R2: The fetch runs as two steps. Step 0 drives ctl = bits {1,3} and step 1 drives ctl = bits {0,4,6}. Bit 0 (program counter increment) is asserted in no other step.
- R3: The opcode is op_nib, which is the upper four bits of the instruction register. It is decoded in step 2. step_idx reads 0 and 1 for the fetch steps and 2 and 3 for the execute steps, and step 3 is always followed by step 0.
- R4: Opcode 0x0 plays bits {7,3} and then {4,8}. Opcode 0x1 plays bits {7,3} and then {4,10}.
- R5: Opcode 0x2 plays bits {7,3} and then {9,5}. Opcode 0x3 plays bits {7,3} and then {11,5}.
- R6: Opcode 0x4 plays a single step, bits {12,8}. The next cycle is step 0, with no idle step in between.
- R7: Opcode 0x5 plays bits {7,3} and then {12,5}.
- R8: Opcode 0x6 plays bits {7,2}. Opcode 0x7 plays bits {9,13}. Opcode 0x8 plays bits {7,3} and then {4,13}.
- R9: Opcodes 0x9 through 0xE each have one decode step (step 2) with ctl = 0, followed directly by step 0.
- R10: Opcode 0xF has a decode step with ctl = 0. From the next cycle on, halted is 1, ctl is 0 and step_idx is 0, whatever op_nib does, until reset.
- R11: Reset taken while halted clears halted and restarts the sequencer at step 0.
- R12: The ctl bit map is fixed. Bit 0 increments the PC, 1 drives the PC out, 2 loads the PC, 3 loads the MAR, 4 drives memory out, 5 writes memory, 6 loads the IR, 7 drives the IR operand out, 8 loads A, 9 drives A out, 10 loads B, 11 drives B out, 12 drives the sum out and 13 loads the output register. At most one bus driver (bits 1, 4, 7, 9, 11, 12) is asserted in any cycle.
- R13: Driving a shared-bus datapath that holds the program 07 18 57 28 70 60 00 01 00 makes the output register take the values 1, 1, 2, 3, 5, and so on, each the 8-bit wrapped sum of the previous two, so that 121 follows 233.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state advances on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_nib | input | 4 | Upper nibble of the instruction register |
| ctl | output | 14 | Control strobe vector, bit map in R12 |
| step_idx | output | 2 | Current micro-step index |
| halted | output | 1 | High once the halt opcode has been decoded |

## Verification
The strobes are decoded combinationally from the state register, so each step's strobes are valid for the whole cycle in which the state holds it. A micro-step therefore appears exactly one cycle after the previous one, and the halted flag rises one cycle after the decode step of opcode 0xF. The instruction register is loaded at the edge that ends step 1, so a new opcode only needs to be valid from step 2. The bench presents the opcode during step 0 and queues one expected item per cycle. It compares each item at the falling edge in the middle of that cycle, so an extra or missing step shifts every item that follows and shows up as a mismatch. The program test attaches a bench model of the datapath that obeys the strobes at each rising edge, and it checks every value captured by the output register.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int OP_W   = 4;
    localparam int CTL_W  = 14;
    localparam int STEP_W = 2;

    // strobe bit positions
    localparam int B_PC_INC    = 0;
    localparam int B_PC_OUT    = 1;
    localparam int B_PC_LOAD   = 2;
    localparam int B_MAR_LD    = 3;
    localparam int B_MEM_RD    = 4;
    localparam int B_MEM_WR    = 5;
    localparam int B_IR_LD     = 6;
    localparam int B_OPND_OUT  = 7;
    localparam int B_A_LD      = 8;
    localparam int B_A_OUT     = 9;
    localparam int B_B_LD      = 10;
    localparam int B_B_OUT     = 11;
    localparam int B_SUM_OUT   = 12;
    localparam int B_OUTREG_LD = 13;

    localparam logic [CTL_W-1:0] M_PC_INC    = CTL_W'(1) << B_PC_INC;
    localparam logic [CTL_W-1:0] M_PC_OUT    = CTL_W'(1) << B_PC_OUT;
    localparam logic [CTL_W-1:0] M_PC_LOAD   = CTL_W'(1) << B_PC_LOAD;
    localparam logic [CTL_W-1:0] M_MAR_LD    = CTL_W'(1) << B_MAR_LD;
    localparam logic [CTL_W-1:0] M_MEM_RD    = CTL_W'(1) << B_MEM_RD;
    localparam logic [CTL_W-1:0] M_MEM_WR    = CTL_W'(1) << B_MEM_WR;
    localparam logic [CTL_W-1:0] M_IR_LD     = CTL_W'(1) << B_IR_LD;
    localparam logic [CTL_W-1:0] M_OPND_OUT  = CTL_W'(1) << B_OPND_OUT;
    localparam logic [CTL_W-1:0] M_A_LD      = CTL_W'(1) << B_A_LD;
    localparam logic [CTL_W-1:0] M_A_OUT     = CTL_W'(1) << B_A_OUT;
    localparam logic [CTL_W-1:0] M_B_LD      = CTL_W'(1) << B_B_LD;
    localparam logic [CTL_W-1:0] M_B_OUT     = CTL_W'(1) << B_B_OUT;
    localparam logic [CTL_W-1:0] M_SUM_OUT   = CTL_W'(1) << B_SUM_OUT;
    localparam logic [CTL_W-1:0] M_OUTREG_LD = CTL_W'(1) << B_OUTREG_LD;

    localparam logic [OP_W-1:0] OP_HALT = 4'hF;

    typedef enum logic [2:0] {
        ST_FETCH_ADDR,
        ST_FETCH_WORD,
        ST_EXEC_A,
        ST_EXEC_B,
        ST_STOPPED
    } useq_state_e;

endpackage

// File: rtl/useq_urom.sv
module useq_urom
    import useq_pkg::*;
(
    input  logic [OP_W-1:0]  op,
    input  logic             second,
    output logic [CTL_W-1:0] ustr,
    output logic             ulast,
    output logic             uhalt
);

    always_comb begin
        ustr  = '0;
        ulast = 1'b1;
        uhalt = 1'b0;
        if (!second) begin
            unique case (op)
                4'h0, 4'h1, 4'h2, 4'h3, 4'h5, 4'h8: begin
                    ustr  = M_OPND_OUT | M_MAR_LD;
                    ulast = 1'b0;
                end
                4'h4:    ustr  = M_SUM_OUT | M_A_LD;
                4'h6:    ustr  = M_OPND_OUT | M_PC_LOAD;
                4'h7:    ustr  = M_A_OUT | M_OUTREG_LD;
                OP_HALT: uhalt = 1'b1;
                default: ustr  = '0;
            endcase
        end else begin
            unique case (op)
                4'h0:    ustr = M_MEM_RD | M_A_LD;
                4'h1:    ustr = M_MEM_RD | M_B_LD;
                4'h2:    ustr = M_A_OUT | M_MEM_WR;
                4'h3:    ustr = M_B_OUT | M_MEM_WR;
                4'h5:    ustr = M_SUM_OUT | M_MEM_WR;
                4'h8:    ustr = M_MEM_RD | M_OUTREG_LD;
                default: ustr = '0;
            endcase
        end
    end

endmodule

// File: rtl/useq_fsm.sv
module useq_fsm
    import useq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ulast,
    input  logic        uhalt,
    output useq_state_e state,
    output logic        second
);

    useq_state_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_FETCH_ADDR;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FETCH_ADDR: state_nx = ST_FETCH_WORD;
            ST_FETCH_WORD: state_nx = ST_EXEC_A;
            ST_EXEC_A: begin
                if (uhalt)      state_nx = ST_STOPPED;
                else if (ulast) state_nx = ST_FETCH_ADDR;
                else            state_nx = ST_EXEC_B;
            end
            ST_EXEC_B:     state_nx = ST_FETCH_ADDR;
            ST_STOPPED:    state_nx = ST_STOPPED;
            default:       state_nx = ST_FETCH_ADDR;
        endcase
    end

    assign second = (state == ST_EXEC_B);

endmodule

// File: rtl/useq_drive.sv
module useq_drive
    import useq_pkg::*;
(
    input  useq_state_e       state,
    input  logic [CTL_W-1:0]  ustr,
    output logic [CTL_W-1:0]  ctl,
    output logic [STEP_W-1:0] step_idx,
    output logic              halted
);

    always_comb begin
        ctl      = '0;
        step_idx = '0;
        halted   = 1'b0;
        unique case (state)
            ST_FETCH_ADDR: ctl = M_PC_OUT | M_MAR_LD;
            ST_FETCH_WORD: begin
                ctl      = M_MEM_RD | M_IR_LD | M_PC_INC;
                step_idx = 2'd1;
            end
            ST_EXEC_A: begin
                ctl      = ustr;
                step_idx = 2'd2;
            end
            ST_EXEC_B: begin
                ctl      = ustr;
                step_idx = 2'd3;
            end
            ST_STOPPED: halted = 1'b1;
            default:    ctl = '0;
        endcase
    end

endmodule

// File: rtl/ucode_seq.sv
module ucode_seq
    import useq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   op_nib,
    output logic [CTL_W-1:0]  ctl,
    output logic [STEP_W-1:0] step_idx,
    output logic              halted
);

    useq_state_e      state;
    logic             second;
    logic [CTL_W-1:0] ustr;
    logic             ulast;
    logic             uhalt;

    useq_urom u_rom (
        .op     (op_nib),
        .second (second),
        .ustr   (ustr),
        .ulast  (ulast),
        .uhalt  (uhalt)
    );

    useq_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .ulast  (ulast),
        .uhalt  (uhalt),
        .state  (state),
        .second (second)
    );

    useq_drive u_drv (
        .state    (state),
        .ustr     (ustr),
        .ctl      (ctl),
        .step_idx (step_idx),
        .halted   (halted)
    );

endmodule

// File: rtl/useq_chk.sv
module useq_chk
    import useq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [CTL_W-1:0]  ctl,
    input logic [STEP_W-1:0] step_idx,
    input logic              halted
);

    // R1
    fetch_addr_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_idx == 2'd0 && !halted) |-> (ctl == (M_PC_OUT | M_MAR_LD)));

    // R2
    fetch_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_idx == 2'd0 && !halted) |=> (step_idx == 2'd1));

    // R2
    pc_inc_only_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl[B_PC_INC] |-> (step_idx == 2'd1));

    // R3
    decode_follows_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_idx == 2'd1) |=> (step_idx == 2'd2));

    // R3
    exec_b_returns_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_idx == 2'd3) |=> (step_idx == 2'd0 && !halted));

    // R10
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R10
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (ctl == '0 && step_idx == 2'd0));

    // R12
    single_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctl[B_PC_OUT], ctl[B_MEM_RD], ctl[B_OPND_OUT],
                  ctl[B_A_OUT], ctl[B_B_OUT], ctl[B_SUM_OUT]}));

endmodule

bind ucode_seq useq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl      (ctl),
    .step_idx (step_idx),
    .halted   (halted)
);

// File: tb/sim_ucode_seq.sv
`timescale 1ns/1ps
module sim_ucode_seq;
    import useq_pkg::*;

    typedef struct {
        logic [CTL_W-1:0] ctl;
        logic [1:0]       step;
        logic             hlt;
        int               req;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [3:0]       drv_op = 4'h0;
    logic [3:0]       op_nib;
    logic [CTL_W-1:0] ctl;
    logic [1:0]       step_idx;
    logic             halted;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    exp_t q[$];

    // bench datapath model for the program test (R13)
    logic       dp_en = 1'b0;
    logic       load_prog = 1'b0;
    logic [7:0] ra, rb, ir, bus, e0, e1;
    logic [3:0] pc, mar;
    logic [7:0] mem [16];
    int         fib_n = 0;

    always #2 clk = ~clk;

    assign op_nib = dp_en ? ir[7:4] : drv_op;

    ucode_seq u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_nib   (op_nib),
        .ctl      (ctl),
        .step_idx (step_idx),
        .halted   (halted)
    );

    task automatic chk(bit ok, string what, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", what, act, expv);
        end
    endtask

    // monitor: one expected item per cycle, compared mid-cycle
    always @(negedge clk) begin
        if (rst_n && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk(ctl == e.ctl, $sformatf("R%0d ctl (R12 bit map)", e.req), int'(ctl), int'(e.ctl));
            chk(step_idx == e.step, "R3 step_idx", int'(step_idx), int'(e.step));
            chk(halted == e.hlt, "R10 halted", int'(halted), int'(e.hlt));
        end
    end

    task automatic add(logic [CTL_W-1:0] c, logic [1:0] s, logic h, int r);
        exp_t e;
        e.ctl = c; e.step = s; e.hlt = h; e.req = r;
        q.push_back(e);
    endtask

    // driver: called at posedge+1 of a step-0 cycle
    task automatic run_op(logic [3:0] op, int halt_cycles);
        drv_op = op;
        add(M_PC_OUT | M_MAR_LD, 2'd0, 1'b0, 2);
        add(M_MEM_RD | M_IR_LD | M_PC_INC, 2'd1, 1'b0, 2);
        case (op)
            4'h0: begin add(M_OPND_OUT | M_MAR_LD, 2, 0, 4); add(M_MEM_RD | M_A_LD, 3, 0, 4); end
            4'h1: begin add(M_OPND_OUT | M_MAR_LD, 2, 0, 4); add(M_MEM_RD | M_B_LD, 3, 0, 4); end
            4'h2: begin add(M_OPND_OUT | M_MAR_LD, 2, 0, 5); add(M_A_OUT | M_MEM_WR, 3, 0, 5); end
            4'h3: begin add(M_OPND_OUT | M_MAR_LD, 2, 0, 5); add(M_B_OUT | M_MEM_WR, 3, 0, 5); end
            4'h4: add(M_SUM_OUT | M_A_LD, 2, 0, 6);
            4'h5: begin add(M_OPND_OUT | M_MAR_LD, 2, 0, 7); add(M_SUM_OUT | M_MEM_WR, 3, 0, 7); end
            4'h6: add(M_OPND_OUT | M_PC_LOAD, 2, 0, 8);
            4'h7: add(M_A_OUT | M_OUTREG_LD, 2, 0, 8);
            4'h8: begin add(M_OPND_OUT | M_MAR_LD, 2, 0, 8); add(M_MEM_RD | M_OUTREG_LD, 3, 0, 8); end
            4'hF: begin
                add('0, 2, 0, 10);
                for (int i = 0; i < halt_cycles; i++) add('0, 0, 1, 10);
            end
            default: add('0, 2, 0, 9);
        endcase
        wait (q.size() == 0);
        @(posedge clk); #1;
    endtask

    // datapath model obeying the strobes (R13)
    always_comb begin
        bus = 8'h00;
        if (ctl[B_A_OUT])    bus = ra;
        if (ctl[B_B_OUT])    bus = rb;
        if (ctl[B_SUM_OUT])  bus = ra + rb;
        if (ctl[B_MEM_RD])   bus = mem[mar];
        if (ctl[B_OPND_OUT]) bus = {4'h0, ir[3:0]};
        if (ctl[B_PC_OUT])   bus = {4'h0, pc};
    end

    always @(posedge clk) begin
        if (load_prog) begin
            for (int i = 0; i < 16; i++) mem[i] <= 8'h00;
            mem[0] <= 8'h07; mem[1] <= 8'h18; mem[2] <= 8'h57;
            mem[3] <= 8'h28; mem[4] <= 8'h70; mem[5] <= 8'h60;
            mem[7] <= 8'h01;
            ra <= 8'h00; rb <= 8'h00; ir <= 8'h00; pc <= 4'h0; mar <= 4'h0;
            e0 <= 8'd1; e1 <= 8'd1;
        end else if (dp_en && rst_n) begin
            if (ctl[B_A_LD])   ra  <= bus;
            if (ctl[B_B_LD])   rb  <= bus;
            if (ctl[B_IR_LD])  ir  <= bus;
            if (ctl[B_MAR_LD]) mar <= bus[3:0];
            if (ctl[B_MEM_WR]) mem[mar] <= bus;
            if (ctl[B_PC_LOAD])     pc <= bus[3:0];
            else if (ctl[B_PC_INC]) pc <= pc + 4'd1;
            if (ctl[B_OUTREG_LD]) begin
                chk(bus == e0, "R13 output register value", int'(bus), int'(e0));
                e0 <= e1;
                e1 <= e0 + e1;
                fib_n++;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(step_idx == 2'd0, "R1 step_idx in reset", int'(step_idx), 0);
        chk(halted == 1'b0, "R1 halted in reset", int'(halted), 0);
        chk(ctl == (M_PC_OUT | M_MAR_LD), "R1 ctl in reset", int'(ctl), int'(M_PC_OUT | M_MAR_LD));
        @(posedge clk); #1;
        rst_n = 1'b1;

        // R4 R5 R6 R7 R8 R9: every opcode, then back-to-back single-step ops
        for (int op = 0; op < 15; op++) run_op(4'(op), 0);
        run_op(4'h4, 0);
        run_op(4'h7, 0);
        run_op(4'h4, 0);

        // R10: halt, then opcode changes must not wake it
        run_op(4'hF, 4);
        drv_op = 4'h4;
        repeat (3) begin
            @(negedge clk);
            chk(halted == 1'b1, "R10 halted held", int'(halted), 1);
            chk(ctl == '0, "R10 ctl quiet", int'(ctl), 0);
        end
        @(posedge clk); #1;

        // R11: reset while halted restarts at step 0
        rst_n = 1'b0;
        @(negedge clk);
        chk(halted == 1'b0, "R11 halted cleared", int'(halted), 0);
        chk(step_idx == 2'd0, "R11 step restart", int'(step_idx), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        run_op(4'h0, 0);
        run_op(4'h5, 0);

        // R13: program on the bench datapath model
        rst_n = 1'b0;
        load_prog = 1'b1;
        @(posedge clk); #1;
        load_prog = 1'b0;
        dp_en = 1'b1;
        rst_n = 1'b1;
        wait (fib_n >= 15);
        @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired fib_n=%0d expected=15", fib_n);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule